// File: doc/BRIEF.md
# Event Counter Bank with Memory-Mapped Control

This block holds a parameterised number of event counters, each 32 or 64 bits wide, behind a simple memory-mapped register interface. Every counter has its own event selector and its own stream-match word. Counting is gated by three things: a global count enable, the counter's enable bit, and the presence of the selected event on the event input bus in that cycle. When an increment carries out of the top bit, the counter wraps to zero. In the same cycle it latches an overflow flag.

The counter-enable, interrupt-enable and overflow-status vectors each have a write-one-to-set address and a write-one-to-clear address. This means software never needs a read-modify-write to change one counter's bit. A level interrupt stays high while any overflow flag is set whose interrupt-enable bit is also set, provided the global interrupt enable is on. A read-only configuration word reports the counter count, the counter width and the filter type. A second read-only pair of words forms a 128-bit map of the supported event codes.

Software can write the counters directly. This lets it preload a start value, such as half of full scale, so that the overflow interrupt arrives after a known number of events. The bus has a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe, flagged by a valid pulse. The reset input is asserted asynchronously and released through a two-flop synchroniser.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter, the counter-enable vector, the interrupt-enable vector, the overflow vector, the global count enable and the global interrupt enable are zero, and `irq` is low.
- R2: The word at 0xE00 reads counters-minus-one in bits 5:0 and counter-width-minus-one in bits 13:8. Bit 23 is the global-filter flag. Bits 20 and 21 read zero.
- R3: Counter n increases by one on each clock in which three conditions hold together: the global count enable (0xE04 bit 0) is set, enable bit n is set, and the event input whose index equals bits 15:0 of its selector word is high. A code at or beyond the number of event inputs never counts. Otherwise the counter holds.
- R4: Writing to 0xC00 sets, and writing to 0xC20 clears, exactly those counter-enable bits written as one. Bits written as zero are left alone. Either address reads back the current vector.
- R5: The interrupt-enable vector behaves the same way, with its set address at 0xC40 and its clear address at 0xC60.
- R6: Counter n is read and written at byte offset n*4 when the width is 32 or less, and at n*8 otherwise.
- R7: An increment from all ones wraps the counter to zero and sets overflow bit n in the same cycle.
- R8: A one written to 0xCC0 sets an overflow bit, and a one written to 0xC80 clears it. Both addresses read the overflow vector. A hardware overflow in the same cycle as a clear of that bit leaves the bit set.
- R9: `irq` is high exactly while the global interrupt enable (0xE50 bit 0) is set and some overflow bit has its interrupt-enable bit set.
- R10: Selector words at 0x400+4n and stream-match words at 0xA00+4n store and return 32 bits.
- R11: Words 0xE20 (low half) and 0xE28 (high half) return the supported-event map parameter, and writes to them have no effect.
- R12: Writes to the configuration word at 0xE00 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| evt_in | input | NUM_EVT | One pulse line per event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
The sharpest corner case is a clear of an overflow bit written in the same cycle as a counter wraps. If the clear were given priority, the overflow would be lost silently, and the bench would read the bit back as zero. The bench preloads counters one or two steps below full scale and checks that the value lands exactly at zero with the flag raised. An off-by-one carry test would instead leave the counter at all ones, or set the flag one event too early. Event codes beyond the input bus, a disabled global enable, and zero bits in set and clear writes are all driven, and the bench then confirms that the affected counters and vectors have not moved. A design that aliased those cases would show stray counts or changed enable bits.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;
  localparam int AW = 12;
  localparam int DW = 64;

  localparam logic [AW-1:0] A_CTR     = 12'h000;
  localparam logic [AW-1:0] A_SEL     = 12'h400;
  localparam logic [AW-1:0] A_MATCH   = 12'hA00;
  localparam logic [AW-1:0] A_CEN_SET = 12'hC00;
  localparam logic [AW-1:0] A_CEN_CLR = 12'hC20;
  localparam logic [AW-1:0] A_IEN_SET = 12'hC40;
  localparam logic [AW-1:0] A_IEN_CLR = 12'hC60;
  localparam logic [AW-1:0] A_OVS_CLR = 12'hC80;
  localparam logic [AW-1:0] A_OVS_SET = 12'hCC0;
  localparam logic [AW-1:0] A_CFG     = 12'hE00;
  localparam logic [AW-1:0] A_RUN     = 12'hE04;
  localparam logic [AW-1:0] A_MAP_LO  = 12'hE20;
  localparam logic [AW-1:0] A_MAP_HI  = 12'hE28;
  localparam logic [AW-1:0] A_IRQ_EN  = 12'hE50;

  function automatic logic [DW-1:0] cfg_word(input int n_ctr, input int width,
                                             input bit glb_filt);
    logic [DW-1:0] w;
    w        = '0;
    w[5:0]   = 6'(n_ctr - 1);
    w[13:8]  = 6'(width - 1);
    w[23]    = glb_filt;
    return w;
  endfunction
endpackage

// File: rtl/perf_ctr_bitvec.sv
module perf_ctr_bitvec #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;
  logic         upd;

  always_comb begin
    upd = set_we | clr_we | (|hw_set);
    q_d = q;
    if (clr_we) q_d = q_d & ~wbits;
    if (set_we) q_d = q_d | wbits;
    q_d = q_d | hw_set;            // hardware event outranks a software clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_d;
  end
endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_d;
  logic         cen;

  always_comb begin
    cen   = wr_en | inc;
    cnt_d = wr_en ? wr_val : cnt + W'(1);
    wrap  = inc & ~wr_en & (&cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (cen) cnt <= cnt_d;
  end
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_ctr_pkg::*;
#(
  parameter int           NUM_CTR     = 4,
  parameter int           CTR_W       = 32,
  parameter int           NUM_EVT     = 8,
  parameter bit           GLOBAL_FILT = 1'b1,
  parameter logic [127:0] EVT_MAP     = 128'h0000_0000_0000_0001_0000_0000_0000_00FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [63:0]        bus_wdata,
  output logic [63:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);
  localparam int STRIDE = (CTR_W > 32) ? 8 : 4;
  localparam int EIW    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  logic [NUM_CTR-1:0]       cnten_q, inten_q, ovs_q, wrap_v;
  logic                     glb_en_q, irq_en_q;
  logic [CTR_W-1:0]         cnt_arr   [NUM_CTR];
  logic [31:0]              sel_q     [NUM_CTR];
  logic [31:0]              match_q   [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;

  // global control bits
  logic run_we, irqc_we;
  assign run_we  = bus_wr && (bus_addr == A_RUN);
  assign irqc_we = bus_wr && (bus_addr == A_IRQ_EN);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      glb_en_q <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (run_we)  glb_en_q <= bus_wdata[0];
      if (irqc_we) irq_en_q <= bus_wdata[0];
    end
  end

  perf_ctr_bitvec #(.N(NUM_CTR)) u_cen (
    .clk(clk), .rst_n(rst_ns),
    .set_we(bus_wr && bus_addr == A_CEN_SET), .clr_we(bus_wr && bus_addr == A_CEN_CLR),
    .wbits(bus_wdata[NUM_CTR-1:0]), .hw_set('0), .q(cnten_q));

  perf_ctr_bitvec #(.N(NUM_CTR)) u_ien (
    .clk(clk), .rst_n(rst_ns),
    .set_we(bus_wr && bus_addr == A_IEN_SET), .clr_we(bus_wr && bus_addr == A_IEN_CLR),
    .wbits(bus_wdata[NUM_CTR-1:0]), .hw_set('0), .q(inten_q));

  perf_ctr_bitvec #(.N(NUM_CTR)) u_ovs (
    .clk(clk), .rst_n(rst_ns),
    .set_we(bus_wr && bus_addr == A_OVS_SET), .clr_we(bus_wr && bus_addr == A_OVS_CLR),
    .wbits(bus_wdata[NUM_CTR-1:0]), .hw_set(wrap_v), .q(ovs_q));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic        ctr_we, sel_we, match_we, evt_hit;
    logic [15:0] code;

    assign ctr_we   = bus_wr && (bus_addr == A_CTR   + AW'(i * STRIDE));
    assign sel_we   = bus_wr && (bus_addr == A_SEL   + AW'(i * 4));
    assign match_we = bus_wr && (bus_addr == A_MATCH + AW'(i * 4));
    assign code     = sel_q[i][15:0];
    assign evt_hit  = (code < 16'(NUM_EVT)) && evt_in[code[EIW-1:0]];

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        sel_q[i]   <= '0;
        match_q[i] <= '0;
      end else begin
        if (sel_we)   sel_q[i]   <= bus_wdata[31:0];
        if (match_we) match_q[i] <= bus_wdata[31:0];
      end
    end

    perf_ctr_slice #(.W(CTR_W)) u_slice (
      .clk(clk), .rst_n(rst_ns), .wr_en(ctr_we), .wr_val(bus_wdata[CTR_W-1:0]),
      .inc(glb_en_q & cnten_q[i] & evt_hit), .cnt(cnt_arr[i]), .wrap(wrap_v[i]));

    assign cnt_flat[i*CTR_W +: CTR_W] = cnt_arr[i];
  end

  // read path
  logic [63:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      A_CEN_SET, A_CEN_CLR: rd_d = 64'(cnten_q);
      A_IEN_SET, A_IEN_CLR: rd_d = 64'(inten_q);
      A_OVS_SET, A_OVS_CLR: rd_d = 64'(ovs_q);
      A_CFG:                rd_d = cfg_word(NUM_CTR, CTR_W, GLOBAL_FILT);
      A_RUN:                rd_d = 64'(glb_en_q);
      A_IRQ_EN:             rd_d = 64'(irq_en_q);
      A_MAP_LO:             rd_d = EVT_MAP[63:0];
      A_MAP_HI:             rd_d = EVT_MAP[127:64];
      default:              rd_d = '0;
    endcase
    for (int k = 0; k < NUM_CTR; k++) begin
      if (bus_addr == A_CTR   + AW'(k * STRIDE)) rd_d = 64'(cnt_arr[k]);
      if (bus_addr == A_SEL   + AW'(k * 4))      rd_d = 64'(sel_q[k]);
      if (bus_addr == A_MATCH + AW'(k * 4))      rd_d = 64'(match_q[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_d;
    end
  end

  assign irq = irq_en_q & (|(ovs_q & inten_q));
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk
  import perf_ctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [11:0]              bus_addr,
  input logic                     irq,
  input logic [NUM_CTR-1:0]       ovs_q,
  input logic [NUM_CTR-1:0]       inten_q,
  input logic [NUM_CTR-1:0]       cnten_q,
  input logic                     glb_en_q,
  input logic                     irq_en_q,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (cnten_q == '0 && inten_q == '0 && ovs_q == '0 && !irq);
    end
  end

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en_q);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(ovs_q & inten_q)));

  p_ovs_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_OVS_CLR) |=> ((ovs_q & $past(ovs_q)) == $past(ovs_q)));

  p_cnten_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(cnten_q));

  p_inten_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(inten_q));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_q && !bus_wr) |=> $stable(cnt_flat));
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq(irq),
  .ovs_q(ovs_q), .inten_q(inten_q), .cnten_q(cnten_q), .glb_en_q(glb_en_q),
  .irq_en_q(irq_en_q), .cnt_flat(cnt_flat));

// File: tb/sim_perf_ctr_bank.sv
`timescale 1ns/1ps
module sim_perf_ctr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  evt_in;
  logic        irq;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;

  always #5 clk = ~clk;

  perf_ctr_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_in(evt_in), .irq(irq));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] v, input int n);
    @(negedge clk);
    evt_in = v;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    chk("R1 irq", {63'b0, irq}, 64'd0);
    rd(12'hC00, d); chk("R1 cnten", d, 64'd0);
    rd(12'hC40, d); chk("R1 inten", d, 64'd0);
    rd(12'hCC0, d); chk("R1 ovs", d, 64'd0);
    rd(12'hE04, d); chk("R1 run", d, 64'd0);
    rd(12'hE50, d); chk("R1 irqen", d, 64'd0);
    rd(12'h004, d); chk("R1 counter1", d, 64'd0);
  endtask

  task automatic t_config;
    logic [63:0] d;
    rd(12'hE00, d); chk("R2 cfg", d, 64'h0080_1F03);
    wr(12'hE00, 64'hFFFF_FFFF);
    rd(12'hE00, d); chk("R12 cfg write ignored", d, 64'h0080_1F03);
    wr(12'hE20, 64'h0);
    rd(12'hE20, d); chk("R11 map low", d, 64'hFF);
    wr(12'hE28, 64'hFFFF);
    rd(12'hE28, d); chk("R11 map high", d, 64'h1);
  endtask

  task automatic t_regs;
    logic [63:0] d;
    wr(12'h408, 64'h2000_0005);
    wr(12'hA0C, 64'h0000_0042);
    rd(12'h408, d); chk("R10 selector 2", d, 64'h2000_0005);
    rd(12'hA0C, d); chk("R10 match 3", d, 64'h42);
    rd(12'hA08, d); chk("R10 match 2 untouched", d, 64'h0);
  endtask

  task automatic t_enables;
    logic [63:0] d;
    wr(12'hC00, 64'h5);
    rd(12'hC00, d); chk("R4 set", d, 64'h5);
    rd(12'hC20, d); chk("R4 clr addr reads", d, 64'h5);
    wr(12'hC20, 64'h4);
    wr(12'hC00, 64'h0);
    rd(12'hC00, d); chk("R4 clear one bit only", d, 64'h1);
    wr(12'hC20, 64'hF);
    wr(12'hC40, 64'hA);
    wr(12'hC60, 64'h2);
    rd(12'hC40, d); chk("R5 set/clear", d, 64'h8);
    wr(12'hC60, 64'hF);
    rd(12'hC60, d); chk("R5 cleared", d, 64'h0);
  endtask

  task automatic t_count;
    logic [63:0] d;
    wr(12'h400, 64'h1);          // counter0: code 1
    wr(12'h404, 64'h2);          // counter1: code 2
    wr(12'h408, 64'h9);          // counter2: code 9, beyond the event bus
    wr(12'hC00, 64'h7);
    wr(12'hE04, 64'h1);
    pulse(8'h02, 5);
    rd(12'h000, d); chk("R3 counter0 counts", d, 64'd5);
    rd(12'h004, d); chk("R3 counter1 other code holds", d, 64'd0);
    pulse(8'hFF, 4);
    rd(12'h000, d); chk("R3 counter0 all events", d, 64'd9);
    rd(12'h004, d); chk("R3 counter1 all events", d, 64'd4);
    rd(12'h008, d); chk("R3 out-of-range code", d, 64'd0);
    wr(12'hE04, 64'h0);
    pulse(8'hFF, 3);
    rd(12'h000, d); chk("R3 global off holds", d, 64'd9);
    wr(12'hE04, 64'h1);
    wr(12'hC20, 64'h1);
    pulse(8'h02, 3);
    rd(12'h000, d); chk("R3 bit off holds", d, 64'd9);
    wr(12'hC20, 64'h7);
  endtask

  task automatic t_preload;
    logic [63:0] d;
    wr(12'h00C, 64'h8000_0000);
    rd(12'h00C, d); chk("R6 preload counter3", d, 64'h8000_0000);
    rd(12'h008, d); chk("R6 neighbour untouched", d, 64'h0);
  endtask

  task automatic t_overflow;
    logic [63:0] d;
    wr(12'h40C, 64'h0);          // counter3: code 0
    wr(12'h00C, 64'hFFFF_FFFE);
    wr(12'hC40, 64'h8);
    wr(12'hE50, 64'h1);
    wr(12'hC00, 64'h8);
    pulse(8'h01, 1);
    rd(12'hCC0, d); chk("R7 no early flag", d, 64'h0);
    pulse(8'h01, 1);
    rd(12'h00C, d); chk("R7 wrap to zero", d, 64'h0);
    rd(12'hC80, d); chk("R8 overflow flag", d, 64'h8);
    chk("R9 irq high", {63'b0, irq}, 64'd1);
    wr(12'hC60, 64'h8);
    chk("R9 irq masked", {63'b0, irq}, 64'd0);
    wr(12'hC40, 64'h8);
    wr(12'hE50, 64'h0);
    chk("R9 irq global off", {63'b0, irq}, 64'd0);
    wr(12'hE50, 64'h1);
    chk("R9 irq back", {63'b0, irq}, 64'd1);
    wr(12'hC80, 64'h8);
    rd(12'hCC0, d); chk("R8 cleared", d, 64'h0);
    chk("R9 irq after clear", {63'b0, irq}, 64'd0);
    wr(12'hCC0, 64'h2);
    rd(12'hCC0, d); chk("R8 software set", d, 64'h2);
  endtask

  task automatic t_race;
    logic [63:0] d;
    wr(12'h00C, 64'hFFFF_FFFF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'hC80; bus_wdata = 64'hA; evt_in = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0; evt_in = '0;
    rd(12'hCC0, d); chk("R8 overflow beats clear", d, 64'h8);
    rd(12'h00C, d); chk("R7 wrapped in race", d, 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1-watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_config;
    t_regs;
    t_enables;
    t_count;
    t_preload;
    t_overflow;
    t_race;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule